// File: doc/BRIEF.md
# SD Card SPI Start-Up Sequencer

This block brings an SD card out of power-up in SPI mode without software help. After reset it holds chip-select inactive while the supply settles. It then clocks out a run of idle bytes and walks the card through the reset, interface-condition, operating-condition and OCR commands. It does not serialise anything itself. Each command goes to a separate command-issuer block through a request/done handshake that returns the first response byte. Any further response bytes are pulled through a raw byte-exchange handshake.

The sequence ends in one of two ways: the card is ready, or a coded error is raised. On either exit chip-select is released and a sticky finished flag is raised. Two flags report the card type: whether the card answered as a version-2 device, and whether it reported high capacity. Parameters set the power-ramp wait in clock cycles, the pause between operating-condition retries, the number of retries and the number of idle bytes.

Top module: `sdspi_boot_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, chip-select is high (inactive), every status output is 0 and no request pulse is raised.
- R2: After reset is released, chip-select stays high and no request is made for at least RAMP_CYC cycles.
- R3: Chip-select then goes low and exactly FILL_BYTES byte exchanges are made before the first command. The exchange port always sends 0xFF.
- R4: The first command is index 0 with argument 0. Any first-byte answer other than 0x01 ends the sequence with the R11 code for that byte, and an answer of 0x00 gives code 1.
- R5: The second command is index 8 with argument 0x1AA. An answer of 0xFF ends the sequence with code 1 (card error).
- R6: An index-8 answer that is not 0xFF and has bit 2 clear raises the version-2 flag and triggers four exchanges. If the fourth byte is not 0xAA, the sequence ends with code 8. Otherwise, if the third byte is not 0x01, it ends with code 9.
- R7: In the version-2 path the block issues index 41 with the application-prefix flag set and argument 0x4000_0000. It repeats this while bit 0 of the answer is 1, up to TRIES attempts in total. Successive attempts start at least RETRY_CYC cycles apart. The application flag is set only for index 41.
- R8: If the last index-41 answer is non-zero, the sequence ends with the R11 code for it, so an answer still showing idle after all tries gives code 2.
- R9: After an index-41 answer of 0, the block issues index 58 with argument 0 and makes four exchanges. It ends with code 0, and the high-capacity flag equals (index-58 answer == 0) AND bit 6 of the first exchanged byte.
- R10: An index-8 answer that is not 0xFF but has bit 2 set takes the version-1 path. Index 58 is issued with no further exchanges, and the sequence ends with code 0 and both card-type flags at 0.
- R11: Error decode of a response byte: 0x00 gives 0 and 0xFF gives 1. Otherwise the lowest set bit picks the code: bit 0 gives 2, bit 1 gives 3, bit 2 gives 4, bit 3 gives 5, bit 4 gives 3, bit 5 gives 6, bit 6 gives 7, and bit 7 alone gives 1.
- R12: On every exit, chip-select goes high and the finished flag rises on the cycle after the deciding done pulse is sampled. Both then hold with the code unchanged, and no further request is made.
- R13: Each request is a one-cycle pulse with chip-select low. Command and exchange requests never coincide, and a new request waits for the previous done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | output | 1 | Card chip-select, active low |
| cmd_go | output | 1 | One-cycle command request to the issuer |
| cmd_app | output | 1 | Issuer must send the application prefix first |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_done | input | 1 | Issuer finished; cmd_r1 valid this cycle |
| cmd_r1 | input | 8 | First response byte from the card |
| xfer_go | output | 1 | One-cycle raw byte-exchange request |
| xfer_tx | output | 8 | Byte sent on each exchange |
| xfer_done | input | 1 | Exchange finished; xfer_rx valid this cycle |
| xfer_rx | input | 8 | Byte received in the exchange |
| init_done | output | 1 | Sequence finished (sticky until reset) |
| err_code | output | 4 | Result code per R11 and R6, valid with init_done |
| is_v2 | output | 1 | Card answered as a version-2 device |
| is_hc | output | 1 | Card reports high capacity |

## Verification
Every result is registered. The finished flag, code and chip-select release are due exactly one cycle after the done pulse that decides the outcome. Each new request is due two cycles after the previous done. The bench records the cycle counter value on every done pulse it drives and samples only on falling edges, so it can check that one-cycle latency exactly. It also measures the first exchange against the reset release for the ramp wait, and the spacing between index-41 requests against RETRY_CYC. A sweep covers every first-command answer, every busy count up to one past the retry limit, and the combinations of card-type bytes.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

  typedef enum logic [3:0] {
    ERR_NONE    = 4'd0,
    ERR_CARD    = 4'd1,
    ERR_IDLE    = 4'd2,
    ERR_ERASE   = 4'd3,
    ERR_ILLEGAL = 4'd4,
    ERR_CRC     = 4'd5,
    ERR_ADDR    = 4'd6,
    ERR_PARAM   = 4'd7,
    ERR_ECHO    = 4'd8,
    ERR_VOLT    = 4'd9
  } err_e;

  typedef enum logic [4:0] {
    ST_BOOT, ST_RAMP, ST_FILL, ST_FILL_W, ST_C0, ST_C0_W, ST_C8, ST_C8_W,
    ST_R7, ST_R7_W, ST_A41, ST_A41_W, ST_GAP, ST_C58, ST_C58_W, ST_OCR,
    ST_OCR_W, ST_END
  } seq_st_e;

  localparam logic [5:0]  IDX_RESET  = 6'd0;
  localparam logic [5:0]  IDX_IFCOND = 6'd8;
  localparam logic [5:0]  IDX_OPCOND = 6'd41;
  localparam logic [5:0]  IDX_OCR    = 6'd58;
  localparam logic [31:0] ARG_IFCOND = 32'h0000_01AA;
  localparam logic [31:0] ARG_HCS    = 32'h4000_0000;
  localparam logic [7:0]  ECHO_BYTE  = 8'hAA;
  localparam logic [7:0]  VOLT_OK    = 8'h01;
  localparam logic [7:0]  IDLE_FILL  = 8'hFF;

endpackage

// File: rtl/sdi_delay.sv
module sdi_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         idle
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= len;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/sdi_r1_decode.sv
module sdi_r1_decode
  import sdi_pkg::*;
(
  input  logic [7:0] r1,
  output err_e       code
);
  always_comb begin
    if (r1 == 8'h00)      code = ERR_NONE;
    else if (r1 == 8'hFF) code = ERR_CARD;
    else if (r1[0])       code = ERR_IDLE;
    else if (r1[1])       code = ERR_ERASE;
    else if (r1[2])       code = ERR_ILLEGAL;
    else if (r1[3])       code = ERR_CRC;
    else if (r1[4])       code = ERR_ERASE;
    else if (r1[5])       code = ERR_ADDR;
    else if (r1[6])       code = ERR_PARAM;
    else                  code = ERR_CARD;
  end
endmodule

// File: rtl/sdspi_boot_seq.sv
module sdspi_boot_seq
  import sdi_pkg::*;
#(
  parameter int RAMP_CYC   = 500000,
  parameter int RETRY_CYC  = 5000000,
  parameter int TRIES      = 10,
  parameter int FILL_BYTES = 80
) (
  input  logic        clk,
  input  logic        rst,
  output logic        cs_n,
  output logic        cmd_go,
  output logic        cmd_app,
  output logic [5:0]  cmd_idx,
  output logic [31:0] cmd_arg,
  input  logic        cmd_done,
  input  logic [7:0]  cmd_r1,
  output logic        xfer_go,
  output logic [7:0]  xfer_tx,
  input  logic        xfer_done,
  input  logic [7:0]  xfer_rx,
  output logic        init_done,
  output logic [3:0]  err_code,
  output logic        is_v2,
  output logic        is_hc
);
  localparam int TMAX = (RAMP_CYC > RETRY_CYC) ? RAMP_CYC : RETRY_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int BW   = $clog2(FILL_BYTES + 1);
  localparam int NW   = $clog2(TRIES + 1);

  seq_st_e       st;
  logic [BW-1:0] nbyte;
  logic [NW-1:0] tries;
  logic [7:0]    vbyte;
  logic          r58_ok;
  logic          tmr_load, tmr_idle;
  logic [TW-1:0] tmr_len;
  logic          retry_now;
  logic          end_now;
  err_e          end_code;
  err_e          dec;

  sdi_delay #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .len(tmr_len), .idle(tmr_idle)
  );

  sdi_r1_decode u_dec (.r1(cmd_r1), .code(dec));

  assign xfer_tx   = IDLE_FILL;
  assign retry_now = (st == ST_A41_W) && cmd_done && cmd_r1[0] &&
                     (tries != NW'(TRIES - 1));
  assign tmr_load  = (st == ST_BOOT) || retry_now;
  assign tmr_len   = (st == ST_BOOT) ? TW'(RAMP_CYC) : TW'(RETRY_CYC);

  // Decide whether this cycle's done pulse terminates the sequence
  always_comb begin
    end_now  = 1'b0;
    end_code = ERR_NONE;
    case (st)
      ST_C0_W: if (cmd_done && cmd_r1 != 8'h01) begin
        end_now  = 1'b1;
        end_code = (cmd_r1 == 8'h00) ? ERR_CARD : dec;
      end
      ST_C8_W: if (cmd_done && cmd_r1 == 8'hFF) begin
        end_now  = 1'b1;
        end_code = dec;
      end
      ST_R7_W: if (xfer_done && nbyte == BW'(3)) begin
        if (xfer_rx != ECHO_BYTE) begin
          end_now  = 1'b1;
          end_code = ERR_ECHO;
        end else if (vbyte != VOLT_OK) begin
          end_now  = 1'b1;
          end_code = ERR_VOLT;
        end
      end
      ST_A41_W: if (cmd_done && !retry_now && cmd_r1 != 8'h00) begin
        end_now  = 1'b1;
        end_code = dec;
      end
      ST_C58_W: if (cmd_done && !is_v2) end_now = 1'b1;
      ST_OCR_W: if (xfer_done && nbyte == BW'(3)) end_now = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_BOOT;
      cs_n      <= 1'b1;
      cmd_go    <= 1'b0;
      cmd_app   <= 1'b0;
      cmd_idx   <= '0;
      cmd_arg   <= '0;
      xfer_go   <= 1'b0;
      init_done <= 1'b0;
      err_code  <= '0;
      is_v2     <= 1'b0;
      is_hc     <= 1'b0;
      nbyte     <= '0;
      tries     <= '0;
      vbyte     <= '0;
      r58_ok    <= 1'b0;
    end else begin
      cmd_go  <= 1'b0;
      xfer_go <= 1'b0;
      if (end_now) begin
        st        <= ST_END;
        cs_n      <= 1'b1;
        init_done <= 1'b1;
        err_code  <= end_code;
      end else begin
        case (st)
          ST_BOOT: st <= ST_RAMP;
          ST_RAMP: if (tmr_idle) begin
            cs_n  <= 1'b0;
            nbyte <= '0;
            st    <= ST_FILL;
          end
          ST_FILL: begin
            xfer_go <= 1'b1;
            st      <= ST_FILL_W;
          end
          ST_FILL_W: if (xfer_done) begin
            if (nbyte == BW'(FILL_BYTES - 1)) st <= ST_C0;
            else begin
              nbyte <= nbyte + 1'b1;
              st    <= ST_FILL;
            end
          end
          ST_C0: begin
            cmd_go  <= 1'b1;
            cmd_app <= 1'b0;
            cmd_idx <= IDX_RESET;
            cmd_arg <= '0;
            st      <= ST_C0_W;
          end
          ST_C0_W: if (cmd_done) st <= ST_C8;
          ST_C8: begin
            cmd_go  <= 1'b1;
            cmd_app <= 1'b0;
            cmd_idx <= IDX_IFCOND;
            cmd_arg <= ARG_IFCOND;
            st      <= ST_C8_W;
          end
          ST_C8_W: if (cmd_done) begin
            if (cmd_r1[2]) st <= ST_C58;
            else begin
              is_v2 <= 1'b1;
              nbyte <= '0;
              st    <= ST_R7;
            end
          end
          ST_R7: begin
            xfer_go <= 1'b1;
            st      <= ST_R7_W;
          end
          ST_R7_W: if (xfer_done) begin
            if (nbyte == BW'(2)) vbyte <= xfer_rx;
            if (nbyte == BW'(3)) begin
              tries <= '0;
              st    <= ST_A41;
            end else begin
              nbyte <= nbyte + 1'b1;
              st    <= ST_R7;
            end
          end
          ST_A41: begin
            cmd_go  <= 1'b1;
            cmd_app <= 1'b1;
            cmd_idx <= IDX_OPCOND;
            cmd_arg <= ARG_HCS;
            st      <= ST_A41_W;
          end
          ST_A41_W: if (cmd_done) begin
            if (retry_now) begin
              tries <= tries + 1'b1;
              st    <= ST_GAP;
            end else st <= ST_C58;
          end
          ST_GAP: if (tmr_idle) st <= ST_A41;
          ST_C58: begin
            cmd_go  <= 1'b1;
            cmd_app <= 1'b0;
            cmd_idx <= IDX_OCR;
            cmd_arg <= '0;
            st      <= ST_C58_W;
          end
          ST_C58_W: if (cmd_done) begin
            r58_ok <= (cmd_r1 == 8'h00);
            nbyte  <= '0;
            st     <= ST_OCR;
          end
          ST_OCR: begin
            xfer_go <= 1'b1;
            st      <= ST_OCR_W;
          end
          ST_OCR_W: if (xfer_done) begin
            if (nbyte == '0) is_hc <= r58_ok & xfer_rx[6];
            nbyte <= nbyte + 1'b1;
            st    <= ST_OCR;
          end
          default: st <= ST_END;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdspi_boot_seq_chk.sv
module sdspi_boot_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        cmd_go,
  input logic        cmd_app,
  input logic [5:0]  cmd_idx,
  input logic [31:0] cmd_arg,
  input logic        xfer_go,
  input logic        init_done,
  input logic [3:0]  err_code,
  input logic        is_v2,
  input logic        is_hc
);
  AST_GO_WITH_CS: assert property (@(posedge clk) disable iff (rst)
    (cmd_go || xfer_go) |-> !cs_n); // R13
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(cmd_go && xfer_go)); // R13
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_go |=> !cmd_go); // R13
  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (rst)
    xfer_go |=> !xfer_go); // R13
  AST_APP_OPCOND: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_app) |-> (cmd_idx == 6'd41 && cmd_arg == 32'h4000_0000)); // R7
  AST_IFCOND_ARG: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_idx == 6'd8) |-> (cmd_arg == 32'h0000_01AA)); // R5
  AST_RESET_ARG: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_idx == 6'd0) |-> (cmd_arg == 32'h0)); // R4
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    init_done |=> (init_done && cs_n && $stable(err_code) && !cmd_go && !xfer_go)); // R12
  AST_ERR_AT_END: assert property (@(posedge clk) disable iff (rst)
    (err_code != 4'd0) |-> init_done); // R12
  AST_HC_NEEDS_V2: assert property (@(posedge clk) disable iff (rst)
    is_hc |-> is_v2); // R9
endmodule

bind sdspi_boot_seq sdspi_boot_seq_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_go(cmd_go), .cmd_app(cmd_app),
  .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .xfer_go(xfer_go),
  .init_done(init_done), .err_code(err_code), .is_v2(is_v2), .is_hc(is_hc)
);

// File: tb/tb_sdspi_boot_seq.sv
`timescale 1ns/1ps
module tb_sdspi_boot_seq;
  localparam int RAMP  = 16;
  localparam int RETRY = 8;
  localparam int TRIES = 3;
  localparam int FILL  = 74;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        cs_n, cmd_go, cmd_app, xfer_go, init_done, is_v2, is_hc;
  logic [5:0]  cmd_idx;
  logic [31:0] cmd_arg;
  logic [7:0]  xfer_tx;
  logic [3:0]  err_code;
  logic        cmd_done = 1'b0, xfer_done = 1'b0;
  logic [7:0]  cmd_r1 = 8'h00, xfer_rx = 8'hFF;

  sdspi_boot_seq #(.RAMP_CYC(RAMP), .RETRY_CYC(RETRY), .TRIES(TRIES),
                   .FILL_BYTES(FILL)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_go(cmd_go), .cmd_app(cmd_app),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_done(cmd_done), .cmd_r1(cmd_r1),
    .xfer_go(xfer_go), .xfer_tx(xfer_tx), .xfer_done(xfer_done),
    .xfer_rx(xfer_rx), .init_done(init_done), .err_code(err_code),
    .is_v2(is_v2), .is_hc(is_hc)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scenario
  logic [7:0] s_r0, s_r8, s_b2, s_b3, s_fin, s_r58, s_ocr0;
  int         s_busy;
  // observations
  int n_fill, n_extra, n_a41, n_cmd, last_done, first_xfer, last_a41, byte_k;
  logic [5:0] last_cmd;
  logic [7:0] rsp;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int dec_exp(input logic [7:0] v);
    if (v == 8'h00) return 0;
    if (v == 8'hFF) return 1;
    if (v[0]) return 2;
    if (v[1]) return 3;
    if (v[2]) return 4;
    if (v[3]) return 5;
    if (v[4]) return 3;
    if (v[5]) return 6;
    if (v[6]) return 7;
    return 1;
  endfunction

  // card and command-issuer model
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_go) begin
        n_cmd++;
        byte_k   = 0;
        last_cmd = cmd_idx;
        chk(cs_n == 1'b0, "R13 cs low on command", int'(cs_n), 0);
        chk(cmd_app == (cmd_idx == 6'd41), "R7 app flag only on 41",
            int'(cmd_app), int'(cmd_idx == 6'd41));
        case (cmd_idx)
          6'd0:  rsp = s_r0;
          6'd8:  rsp = s_r8;
          6'd41: begin
            if (n_a41 > 0)
              chk(cyc - last_a41 >= RETRY, "R7 retry spacing", cyc - last_a41, RETRY);
            chk(cmd_arg == 32'h4000_0000, "R7 argument", int'(cmd_arg), 32'h4000_0000);
            last_a41 = cyc;
            rsp = (n_a41 < s_busy) ? 8'h01 : s_fin;
            n_a41++;
          end
          6'd58: begin
            chk(cmd_arg == 32'h0, "R9 argument", int'(cmd_arg), 0);
            rsp = s_r58;
          end
          default: begin
            chk(1'b0, "R13 unknown command", int'(cmd_idx), 0);
            rsp = 8'hFF;
          end
        endcase
        @(negedge clk);
        cmd_r1 = rsp; cmd_done = 1'b1; last_done = cyc;
        @(negedge clk);
        cmd_done = 1'b0;
      end else if (xfer_go) begin
        if (first_xfer < 0) first_xfer = cyc;
        chk(xfer_tx == 8'hFF, "R3 fill byte", int'(xfer_tx), 255);
        if (n_cmd == 0) begin
          n_fill++;
          rsp = 8'hFF;
        end else begin
          n_extra++;
          if (last_cmd == 6'd8) rsp = (byte_k == 2) ? s_b2 : (byte_k == 3) ? s_b3 : 8'h00;
          else                  rsp = (byte_k == 0) ? s_ocr0 : 8'h00;
          byte_k++;
        end
        @(negedge clk);
        xfer_rx = rsp; xfer_done = 1'b1; last_done = cyc;
        @(negedge clk);
        xfer_done = 1'b0;
      end
    end
  end

  task automatic run_case(input logic [7:0] r0, input logic [7:0] r8,
                          input logic [7:0] b2, input logic [7:0] b3,
                          input int busy, input logic [7:0] fin,
                          input logic [7:0] r58, input logic [7:0] ocr0);
    int e_err, e_v2, e_hc, e_extra, e_a41, rel, tmo, ncmd_end;
    @(negedge clk);
    rst = 1'b1;
    s_r0 = r0; s_r8 = r8; s_b2 = b2; s_b3 = b3; s_busy = busy;
    s_fin = fin; s_r58 = r58; s_ocr0 = ocr0;
    n_fill = 0; n_extra = 0; n_a41 = 0; n_cmd = 0; first_xfer = -1;
    last_a41 = 0; last_done = 0;
    repeat (2) @(negedge clk);
    chk(cs_n == 1'b1 && !cmd_go && !xfer_go, "R1 reset chip-select/requests", int'(cs_n), 1);
    chk(!init_done && err_code == 4'd0 && !is_v2 && !is_hc, "R1 reset status",
        int'(err_code), 0);
    rst = 1'b0;
    rel = cyc;
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1, "R2 chip-select high during ramp", int'(cs_n), 1);

    // expected outcome from the requirements
    e_v2 = 0; e_hc = 0; e_extra = 0; e_a41 = 0;
    if (r0 != 8'h01)       e_err = (r0 == 8'h00) ? 1 : dec_exp(r0);
    else if (r8 == 8'hFF)  e_err = 1;
    else if (r8[2])        e_err = 0;
    else begin
      e_v2 = 1; e_extra = 4;
      if (b3 != 8'hAA)      e_err = 8;
      else if (b2 != 8'h01) e_err = 9;
      else begin
        e_a41 = (busy < TRIES) ? busy + 1 : TRIES;
        if (busy >= TRIES)      e_err = 2;
        else if (fin != 8'h00)  e_err = dec_exp(fin);
        else begin
          e_err = 0; e_extra = 8;
          e_hc = (r58 == 8'h00 && ocr0[6]) ? 1 : 0;
        end
      end
    end

    tmo = 0;
    while (!init_done && tmo < 4000) begin
      @(negedge clk);
      tmo++;
    end
    chk(init_done == 1'b1, "R12 sequence finished", int'(init_done), 1);
    chk(cyc - last_done == 1, "R12 finish latency", cyc - last_done, 1);
    chk(first_xfer - rel >= RAMP, "R2 ramp wait", first_xfer - rel, RAMP);
    chk(n_fill == FILL, "R3 fill count", n_fill, FILL);
    chk(int'(err_code) == e_err, "R11 result code", int'(err_code), e_err);
    chk(int'(is_v2) == e_v2, "R6 version-2 flag", int'(is_v2), e_v2);
    chk(int'(is_hc) == e_hc, "R9 high-capacity flag", int'(is_hc), e_hc);
    chk(n_extra == e_extra, "R6 extra exchanges", n_extra, e_extra);
    chk(n_a41 == e_a41, "R7 attempts", n_a41, e_a41);
    ncmd_end = n_cmd;
    repeat (6) @(negedge clk);
    chk(cs_n == 1'b1 && init_done == 1'b1, "R12 hold after finish", int'(cs_n), 1);
    chk(n_cmd == ncmd_end, "R12 no request after finish", n_cmd, ncmd_end);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
    finish_run();
  end

  initial begin
    // R4 and R11: every first-command answer other than 0x01
    for (int v = 0; v < 256; v++)
      if (v != 1) run_case(8'(v), 8'h01, 8'h01, 8'hAA, 0, 8'h00, 8'h00, 8'h40);
    // R5: no answer to interface condition
    run_case(8'h01, 8'hFF, 8'h01, 8'hAA, 0, 8'h00, 8'h00, 8'h40);
    // R10: version-1 path
    run_case(8'h01, 8'h05, 8'h01, 8'hAA, 0, 8'h00, 8'h00, 8'h40);
    run_case(8'h01, 8'h04, 8'h01, 8'hAA, 0, 8'h00, 8'h00, 8'h40);
    run_case(8'h01, 8'h0C, 8'h01, 8'hAA, 0, 8'h00, 8'h00, 8'h40);
    // R6: echo and voltage errors
    run_case(8'h01, 8'h01, 8'h01, 8'h55, 0, 8'h00, 8'h00, 8'h40);
    run_case(8'h01, 8'h01, 8'h02, 8'hAA, 0, 8'h00, 8'h00, 8'h40);
    run_case(8'h01, 8'h01, 8'h02, 8'h00, 0, 8'h00, 8'h00, 8'h40);
    // R7 and R8: busy sweep through the retry limit
    for (int b = 0; b <= TRIES + 1; b++)
      run_case(8'h01, 8'h01, 8'h01, 8'hAA, b, 8'h00, 8'h00, 8'h40);
    run_case(8'h01, 8'h00, 8'h01, 8'hAA, 1, 8'h04, 8'h00, 8'h40);
    run_case(8'h01, 8'h01, 8'h01, 8'hAA, 2, 8'h20, 8'h00, 8'h40);
    run_case(8'h01, 8'h01, 8'h01, 8'hAA, 0, 8'h80, 8'h00, 8'h40);
    // R9: capacity flag combinations
    for (int r = 0; r < 2; r++)
      for (int o = 0; o < 3; o++)
        run_case(8'h01, 8'h01, 8'h01, 8'hAA, 1, 8'h00, 8'(r),
                 (o == 0) ? 8'h00 : (o == 1) ? 8'h40 : 8'hFF);
    finish_run();
  end
endmodule